// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This controller decides what happens when the processor reports that it has executed a stop instruction. On that strobe it samples five configuration bits. It then does one of three things: it requests an illegal-opcode reset, it parks the chip in a shallow stop that keeps its state, or it parks the chip in a deep stop. While the chip is parked, the controller drives the main clock-gate enable, a keep-alive for the debug clock domain and a request that puts the supply regulator into standby.

While the chip is stopped, the controller watches a vector of asynchronous wake requests and the external reset pin, each through a two-flop synchroniser. When a qualifying event arrives it returns the chip to run, pulses an exit marker for one cycle and reports whether the return counts as a reset or as an interrupt. The wake vector holds 16 pin interrupts at bits 0..15, then low-voltage reset (bit 16), low-voltage warning, conversion done, comparator, timer tick, serial-link wake and serial receive (bits 17..22). The parameter `RST_SRC_MASK` marks which of these count as reset-class. By default only bit 16 does.

Top module: `stop_ctl`

## Requirements
- R1: A stop strobe taken in run with `cfg_stop_en`=0 raises `ilop_rst` for exactly the one cycle after the strobe edge, and `mode_st` stays 00.
- R2: With stop enabled and `cfg_dbg_en`=1, the next state is shallow stop, with `dbg_clk_keep`=1 and `reg_stby`=0.
- R3: With stop enabled, debug off and both `cfg_lvd_en` and `cfg_lvd_stop` at 1, the next state is shallow stop, with `dbg_clk_keep`=0 and `reg_stby`=0.
- R4: In every other enabled case, `cfg_ppd`=0 gives shallow stop and `cfg_ppd`=1 gives deep stop. Both set `reg_stby`=1 and `dbg_clk_keep`=0.
- R5: `mode_st` encodes run=00, shallow=01 and deep=10, and never shows 11. `clk_run` is 1 exactly while `mode_st`=00. In run, `reg_stby` and `dbg_clk_keep` are 0.
- R6: Shallow stop ends when the reset pin or any wake bit enabled in `wake_en` is held. The state returns to run on the third rising edge after the input rises. A wake bit whose enable is 0 has no effect.
- R7: On exit, `exit_rst`=1 when the reset pin or a reset-class wake bit caused it, and `exit_rst`=0 when only interrupt sources did. The value holds until the next exit.
- R8: Deep stop ignores interrupt-class wake bits. Only the reset pin or reset-class bits end it, and the exit always reports `exit_rst`=1.
- R9: While the chip is stopped, changes on the `cfg_*` inputs leave `mode_st`, `reg_stby` and `dbg_clk_keep` unchanged.
- R10: A stop strobe that meets an already synchronised enabled wake or reset-pin request is cancelled. The state stays 00, with no exit pulse and no illegal-opcode reset.
- R11: `exit_pulse` is high for exactly the first run cycle after each exit, and is never high twice in a row.
- R12: After reset, `mode_st`=00, `clk_run`=1, and `ilop_rst`, `exit_pulse`, `exit_rst`, `reg_stby` and `dbg_clk_keep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_stop_en | input | 1 | Stop instruction permitted |
| cfg_dbg_en | input | 1 | Debug enabled; keeps the debug clocks and the regulator alive |
| cfg_lvd_en | input | 1 | Low-voltage detector enabled |
| cfg_lvd_stop | input | 1 | Low-voltage detector kept on during stop |
| cfg_ppd | input | 1 | Partial power-down select (1 = deep stop) |
| stop_req | input | 1 | One-cycle strobe: stop instruction executed |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| wake_req | input | NUM_WAKE | Asynchronous wake requests |
| wake_en | input | NUM_WAKE | Per-source wake enables |
| mode_st | output | 2 | Current state: 00 run, 01 shallow, 10 deep |
| clk_run | output | 1 | Main clock-gate enable |
| dbg_clk_keep | output | 1 | Keep debug clocks running during stop |
| reg_stby | output | 1 | Regulator standby request |
| ilop_rst | output | 1 | Illegal-opcode reset request pulse |
| exit_pulse | output | 1 | One-cycle marker for each stop exit |
| exit_rst | output | 1 | Cause of the last exit: 1 reset, 0 interrupt |

## Verification
The bench sweeps all 32 settings of the five configuration bits through entry and exit. A decode with the wrong priority would show the wrong `mode_st`, or would raise the regulator standby request while debug or low-voltage-in-stop should hold the regulator active. In deep stop it holds an interrupt pin high first. A controller that wrongly let interrupts wake deep stop would return to run and report an interrupt cause. Exit timing is sampled one cycle before and on the third edge, so a missing or extra synchroniser stage shows up as an early or late return. The bench also covers a strobe that meets a pending wake, flips the configuration during stop, and holds a masked wake bit. A design that ignored the cancel, kept the configuration live or skipped the enable mask would leave run, change its gating or wake up early.

// File: rtl/stop_ctl_pkg.sv
package stop_ctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_SHALLOW = 2'b01,
    ST_DEEP    = 2'b10
  } pwr_state_e;

  typedef struct packed {
    pwr_state_e depth;
    logic       keep_dbg;
    logic       stby;
  } stop_plan_t;
endpackage

// File: rtl/stop_wake_sync.sv
module stop_wake_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
      end
    end
    assign sync_out[i] = s2;
  end
endmodule

// File: rtl/stop_mode_decode.sv
module stop_mode_decode
  import stop_ctl_pkg::*;
(
  input  logic       dbg_en,
  input  logic       lvd_en,
  input  logic       lvd_stop,
  input  logic       ppd,
  output stop_plan_t plan
);
  logic lvd_hold;
  assign lvd_hold = lvd_en & lvd_stop;

  always_comb begin
    plan.keep_dbg = 1'b0;
    plan.stby     = 1'b1;
    plan.depth    = ST_SHALLOW;
    if (dbg_en) begin
      plan.keep_dbg = 1'b1;
      plan.stby     = 1'b0;
    end else if (lvd_hold) begin
      plan.stby     = 1'b0;
    end else if (ppd) begin
      plan.depth    = ST_DEEP;
    end
  end
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import stop_ctl_pkg::*;
#(
  parameter int              NUM_WAKE     = 23,
  parameter logic [NUM_WAKE-1:0] RST_SRC_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                stop_en,
  input  stop_plan_t          plan,
  input  logic                s_rst_pin,
  input  logic [NUM_WAKE-1:0] s_wake,
  input  logic [NUM_WAKE-1:0] wake_en,
  output pwr_state_e          state,
  output logic                keep_dbg_q,
  output logic                stby_q,
  output logic                ilop_q,
  output logic                exit_q,
  output logic                cause_rst_q
);
  logic [NUM_WAKE-1:0] live;
  logic any_int, any_rst, any_evt;

  assign live    = s_wake & wake_en;
  assign any_rst = s_rst_pin | (|(live & RST_SRC_MASK));
  assign any_int = |(live & ~RST_SRC_MASK);
  assign any_evt = any_rst | any_int;

  pwr_state_e state_d;
  logic keep_d, stby_d, ilop_d, exit_d, cause_d;

  always_comb begin
    state_d = state;
    keep_d  = keep_dbg_q;
    stby_d  = stby_q;
    ilop_d  = 1'b0;
    exit_d  = 1'b0;
    cause_d = cause_rst_q;
    unique case (state)
      ST_RUN: begin
        if (stop_req) begin
          if (!stop_en) begin
            ilop_d = 1'b1;
          end else if (!any_evt) begin
            state_d = plan.depth;
            keep_d  = plan.keep_dbg;
            stby_d  = plan.stby;
          end
        end
      end
      ST_SHALLOW: begin
        if (any_evt) begin
          state_d = ST_RUN;
          exit_d  = 1'b1;
          cause_d = any_rst;
          keep_d  = 1'b0;
          stby_d  = 1'b0;
        end
      end
      ST_DEEP: begin
        if (any_rst) begin
          state_d = ST_RUN;
          exit_d  = 1'b1;
          cause_d = 1'b1;
          keep_d  = 1'b0;
          stby_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_RUN;
        keep_d  = 1'b0;
        stby_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      keep_dbg_q  <= 1'b0;
      stby_q      <= 1'b0;
      ilop_q      <= 1'b0;
      exit_q      <= 1'b0;
      cause_rst_q <= 1'b0;
    end else begin
      state       <= state_d;
      keep_dbg_q  <= keep_d;
      stby_q      <= stby_d;
      ilop_q      <= ilop_d;
      exit_q      <= exit_d;
      cause_rst_q <= cause_d;
    end
  end
endmodule

// File: rtl/stop_ctl.sv
module stop_ctl
  import stop_ctl_pkg::*;
#(
  parameter int              NUM_WAKE     = 23,
  parameter int              LVR_BIT      = 16,
  parameter logic [NUM_WAKE-1:0] RST_SRC_MASK = NUM_WAKE'(1) << LVR_BIT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_stop_en,
  input  logic                cfg_dbg_en,
  input  logic                cfg_lvd_en,
  input  logic                cfg_lvd_stop,
  input  logic                cfg_ppd,
  input  logic                stop_req,
  input  logic                rst_pin,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  output logic [1:0]          mode_st,
  output logic                clk_run,
  output logic                dbg_clk_keep,
  output logic                reg_stby,
  output logic                ilop_rst,
  output logic                exit_pulse,
  output logic                exit_rst
);
  localparam int SYNC_W = NUM_WAKE + 1;

  logic [SYNC_W-1:0] sync_q;
  stop_plan_t        plan;
  pwr_state_e        state;

  stop_wake_sync #(.W(SYNC_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({rst_pin, wake_req}),
    .sync_out (sync_q)
  );

  stop_mode_decode u_dec (
    .dbg_en   (cfg_dbg_en),
    .lvd_en   (cfg_lvd_en),
    .lvd_stop (cfg_lvd_stop),
    .ppd      (cfg_ppd),
    .plan     (plan)
  );

  stop_fsm #(.NUM_WAKE(NUM_WAKE), .RST_SRC_MASK(RST_SRC_MASK)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .stop_en     (cfg_stop_en),
    .plan        (plan),
    .s_rst_pin   (sync_q[NUM_WAKE]),
    .s_wake      (sync_q[NUM_WAKE-1:0]),
    .wake_en     (wake_en),
    .state       (state),
    .keep_dbg_q  (dbg_clk_keep),
    .stby_q      (reg_stby),
    .ilop_q      (ilop_rst),
    .exit_q      (exit_pulse),
    .cause_rst_q (exit_rst)
  );

  assign mode_st = state;
  assign clk_run = (state == ST_RUN);
endmodule

// File: rtl/stop_ctl_chk.sv
module stop_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_stop_en,
  input logic       stop_req,
  input logic [1:0] mode_st,
  input logic       clk_run,
  input logic       dbg_clk_keep,
  input logic       reg_stby,
  input logic       ilop_rst,
  input logic       exit_pulse,
  input logic       exit_rst
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_st != 2'b11); // R5
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_st == 2'b00) |-> (!reg_stby && !dbg_clk_keep && clk_run)); // R5
  AST_ILOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ilop_rst |-> ($past(stop_req) && !$past(cfg_stop_en) && $past(mode_st) == 2'b00 && mode_st == 2'b00)); // R1
  AST_DBG_NO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clk_keep |-> !reg_stby); // R2
  AST_DEEP_EXIT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pulse && $past(mode_st) == 2'b10) |-> exit_rst); // R8
  AST_EXIT_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> ($past(mode_st) != 2'b00 && mode_st == 2'b00)); // R6
  AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse); // R11
  AST_STOP_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_st != 2'b00 && $past(mode_st) == mode_st) |-> ($stable(reg_stby) && $stable(dbg_clk_keep))); // R9
endmodule

bind stop_ctl stop_ctl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_stop_en  (cfg_stop_en),
  .stop_req     (stop_req),
  .mode_st      (mode_st),
  .clk_run      (clk_run),
  .dbg_clk_keep (dbg_clk_keep),
  .reg_stby     (reg_stby),
  .ilop_rst     (ilop_rst),
  .exit_pulse   (exit_pulse),
  .exit_rst     (exit_rst)
);

// File: tb/stop_ctl_tb_top.sv
module stop_ctl_tb_top;
  localparam int NW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_stop_en = 0, cfg_dbg_en = 0, cfg_lvd_en = 0, cfg_lvd_stop = 0, cfg_ppd = 0;
  logic stop_req = 0, rst_pin = 0;
  logic [NW-1:0] wake_req = '0;
  logic [NW-1:0] wake_en = '1;
  logic [1:0] mode_st;
  logic clk_run, dbg_clk_keep, reg_stby, ilop_rst, exit_pulse, exit_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  stop_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_stop_en(cfg_stop_en), .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en),
    .cfg_lvd_stop(cfg_lvd_stop), .cfg_ppd(cfg_ppd),
    .stop_req(stop_req), .rst_pin(rst_pin), .wake_req(wake_req), .wake_en(wake_en),
    .mode_st(mode_st), .clk_run(clk_run), .dbg_clk_keep(dbg_clk_keep),
    .reg_stby(reg_stby), .ilop_rst(ilop_rst), .exit_pulse(exit_pulse), .exit_rst(exit_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitn(3);
    // R12 reset state
    chk("R12 mode", mode_st, 0);
    chk("R12 clk_run", clk_run, 1);
    chk("R12 outs", {ilop_rst, exit_pulse, exit_rst, reg_stby, dbg_clk_keep}, 0);
    rst_n = 1'b1;
    waitn(2);

    // Sweep of all control combinations
    for (int c = 0; c < 32; c++) begin
      int exp_mode, exp_keep, exp_stby, src, exp_cause;
      string tag;
      cfg_stop_en = c[0]; cfg_dbg_en = c[1]; cfg_lvd_en = c[2];
      cfg_lvd_stop = c[3]; cfg_ppd = c[4];
      exp_keep = c[1];
      exp_stby = (!c[1] && !(c[2] && c[3])) ? 1 : 0;
      exp_mode = c[1] ? 1 : ((c[2] && c[3]) ? 1 : (c[4] ? 2 : 1));
      tag = c[1] ? "R2" : ((c[2] && c[3]) ? "R3" : "R4");
      stop_req = 1'b1;
      waitn(1);
      stop_req = 1'b0;
      if (!c[0]) begin
        chk("R1 ilop pulse", ilop_rst, 1);
        chk("R1 stays run", mode_st, 0);
        waitn(1);
        chk("R1 ilop one cycle", ilop_rst, 0);
        continue;
      end
      chk({tag, " mode"}, mode_st, exp_mode);
      chk({tag, " dbg keep"}, dbg_clk_keep, exp_keep);
      chk({tag, " stby"}, reg_stby, exp_stby);
      chk("R5 clk gated", clk_run, 0);
      chk("R1 no ilop", ilop_rst, 0);
      // R9: flip config during stop
      {cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop, cfg_ppd} = ~{c[0], c[1], c[2], c[3], c[4]};
      waitn(2);
      chk("R9 mode held", mode_st, exp_mode);
      chk("R9 gating held", {dbg_clk_keep, reg_stby}, exp_keep * 2 + exp_stby);
      if (exp_mode == 2) begin
        wake_req[c % 16] = 1'b1;
        waitn(5);
        chk("R8 interrupt ignored in deep", mode_st, 2);
        wake_req = '0;
        waitn(3);
      end
      src = c % 3;
      if (exp_mode == 2 && src == 0) src = 2;
      exp_cause = (src == 0) ? 0 : 1;
      if (src == 0) wake_req[(c + 3) % 16] = 1'b1;
      else if (src == 1) wake_req[16] = 1'b1;
      else rst_pin = 1'b1;
      waitn(2);
      chk("R6 not yet awake", mode_st, exp_mode);
      chk("R11 no early pulse", exit_pulse, 0);
      waitn(1);
      chk("R6 back to run", mode_st, 0);
      chk("R11 exit pulse", exit_pulse, 1);
      chk(exp_mode == 2 ? "R8 deep cause" : "R7 cause", exit_rst, exp_cause);
      wake_req = '0;
      rst_pin = 1'b0;
      waitn(1);
      chk("R11 pulse single", exit_pulse, 0);
      chk("R7 cause held", exit_rst, exp_cause);
      waitn(3);
    end

    // R10: strobe meets synchronised wake
    cfg_stop_en = 1; cfg_dbg_en = 0; cfg_lvd_en = 0; cfg_lvd_stop = 0; cfg_ppd = 0;
    wake_req[5] = 1'b1;
    waitn(3);
    stop_req = 1'b1;
    waitn(1);
    stop_req = 1'b0;
    chk("R10 entry cancelled", mode_st, 0);
    chk("R10 no ilop", ilop_rst, 0);
    chk("R10 no exit pulse", exit_pulse, 0);
    wake_req = '0;
    waitn(3);

    // R6: masked wake source ignored
    wake_en[3] = 1'b0;
    stop_req = 1'b1;
    waitn(1);
    stop_req = 1'b0;
    chk("R6 entered shallow", mode_st, 1);
    wake_req[3] = 1'b1;
    waitn(5);
    chk("R6 masked wake ignored", mode_st, 1);
    wake_en[3] = 1'b1;
    waitn(3);
    chk("R6 unmasked wake exits", mode_st, 0);
    chk("R7 interrupt cause", exit_rst, 0);
    wake_req = '0;
    waitn(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule